// File: doc/BRIEF.md
# Converter Sample Queue and Interrupt Register Bank

This block sits between an analog-to-digital conversion engine and a processor. The engine pushes each finished 16-bit result through a one-cycle write strobe into a 16-entry first-in first-out queue. The processor reaches the queue and a handful of control and interrupt registers over a simple single-beat 32-bit register bus. One bus read of the data location returns the oldest stored result and removes it.

An interrupt line tells the processor that results are waiting. It is the AND of a global enable, a per-source enable and a status bit. The status bit follows the queue's non-empty state, and a bus write of one can flip it for a cycle. A control register gives the conversion engine two settings: its run enable and its settle-time multiplier.

The bus handshake is a three-state machine: `BUS_IDLE`, `BUS_ACK` and `BUS_RECOVER`. Its transitions are:
- `BUS_IDLE` goes to `BUS_ACK` when select is seen.
- `BUS_ACK` always goes to `BUS_RECOVER`. This state drives the acknowledge, and the register access takes place on the clock edge that leaves it.
- `BUS_RECOVER` goes back to `BUS_IDLE` once select is low. It stays in `BUS_RECOVER` while select is still held.

Only the low 9 address bits are decoded. Base decoding is left to the surrounding fabric.

Top module: `sample_regbank`

## Requirements
- R1: After a synchronous reset, every register reads zero, and the acknowledge, interrupt and queue-full outputs are low.
- R2: The acknowledge rises in the clock cycle after select is first sampled high and stays high for exactly one cycle. Each assertion of select causes exactly one register access.
- R3: The control register at offset 0x100 holds the conversion enable in bit 31 and the settle multiplier in bits SM_W-1:0. Both drive the outputs of the same name, and all other bits read zero.
- R4: A read of offset 0x104 returns the oldest queued sample in bits 15:0, with zeros above, and removes that sample. Samples come out in the order they were pushed.
- R5: A read of offset 0x104 while the queue is empty returns zero and leaves the queue unchanged.
- R6: Offset 0x108 reads the queue entry count minus one in bits 4:0, and zero when the queue is empty. One entry reads 0, nine entries read 8, sixteen entries read 15.
- R7: The full output is high when the queue holds 16 entries. A sample pushed while full is discarded.
- R8: Bit 0 of the status register at offset 0x020 equals the queue's non-empty state one cycle later, in every cycle with no toggle write.
- R9: A bus write to offset 0x020 with bit 0 set inverts the status bit for that cycle. A write with bit 0 clear has no effect.
- R10: The interrupt output is high exactly when all three of these bits are set: the global enable (bit 31 of offset 0x01C), the status bit, and the source enable (bit 0 of offset 0x028).
- R11: Writes to offsets 0x104 and 0x108 change nothing, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus select |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | ADDR_W | Byte address; the low 9 bits are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while acknowledge is high |
| bus_ack | output | 1 | Transfer acknowledge |
| smp_wr | input | 1 | Sample push strobe from the converter |
| smp_data | input | SMP_W | Sample value |
| smp_full | output | 1 | Queue full |
| conv_en | output | 1 | Conversion enable |
| settle_mult | output | SM_W | Settle-time multiplier |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default parameters: a queue depth of 16, a 4-bit settle multiplier and 16-bit samples. At depth 16, a full queue, the overflow drop and the occupancy values at one, nine and sixteen entries are all reached within a few hundred cycles. With a 4-bit multiplier field, an all-ones control write shows that bits 30:4 are masked to zero.

// File: rtl/smpbank_pkg.sv
package smpbank_pkg;
    localparam int OFS_W = 9;
    localparam logic [OFS_W-1:0] OFS_GIE  = 9'h01C;
    localparam logic [OFS_W-1:0] OFS_STAT = 9'h020;
    localparam logic [OFS_W-1:0] OFS_IEN  = 9'h028;
    localparam logic [OFS_W-1:0] OFS_CTRL = 9'h100;
    localparam logic [OFS_W-1:0] OFS_DATA = 9'h104;
    localparam logic [OFS_W-1:0] OFS_OCC  = 9'h108;

    typedef enum logic [1:0] {
        BUS_IDLE    = 2'd0,
        BUS_ACK     = 2'd1,
        BUS_RECOVER = 2'd2
    } bus_state_t;
endpackage

// File: rtl/bus_fsm.sv
module bus_fsm
    import smpbank_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel,
    output logic ack
);
    bus_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= BUS_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        ack      = 1'b0;
        unique case (state)
            BUS_IDLE:    if (sel) state_nx = BUS_ACK;
            BUS_ACK: begin
                ack      = 1'b1;
                state_nx = BUS_RECOVER;
            end
            BUS_RECOVER: if (!sel) state_nx = BUS_IDLE;
            default:     state_nx = BUS_IDLE;
        endcase
    end

    // R2: acknowledge lasts a single cycle
    assert_ack_single_R2: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    // R2: acknowledge only follows a sampled select
    assert_ack_after_sel_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(sel));
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH-1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_MAX);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_MAX);
    assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == CNT_MAX));
    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/sample_regbank.sv
module sample_regbank
    import smpbank_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 16,
    parameter int SMP_W  = 16,
    parameter int SM_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_rnw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ack,
    input  logic              smp_wr,
    input  logic [SMP_W-1:0]  smp_data,
    output logic              smp_full,
    output logic              conv_en,
    output logic [SM_W-1:0]   settle_mult,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic              ack;
    logic [OFS_W-1:0]  ofs;
    logic              wr_hit, rd_hit, tog_hit, pop_req;
    logic [SMP_W-1:0]  fifo_head;
    logic              fifo_empty, fifo_full;
    logic [CNT_W-1:0]  fifo_count, occ;
    logic              gie, ien, stat_ne;

    bus_fsm u_fsm (.clk(clk), .rst(rst), .sel(bus_sel), .ack(ack));

    assign ofs     = bus_addr[OFS_W-1:0];
    assign wr_hit  = ack && !bus_rnw;
    assign rd_hit  = ack && bus_rnw;
    assign pop_req = rd_hit && (ofs == OFS_DATA);
    assign tog_hit = wr_hit && (ofs == OFS_STAT) && bus_wdata[0];

    sample_fifo #(.DEPTH(DEPTH), .W(SMP_W)) u_fifo (
        .clk(clk), .rst(rst), .push(smp_wr), .din(smp_data), .pop(pop_req),
        .head(fifo_head), .empty(fifo_empty), .full(fifo_full), .count(fifo_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gie         <= 1'b0;
            ien         <= 1'b0;
            conv_en     <= 1'b0;
            settle_mult <= '0;
        end else if (wr_hit) begin
            if (ofs == OFS_GIE) gie <= bus_wdata[31];
            if (ofs == OFS_IEN) ien <= bus_wdata[0];
            if (ofs == OFS_CTRL) begin
                conv_en     <= bus_wdata[31];
                settle_mult <= bus_wdata[SM_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          stat_ne <= 1'b0;
        else if (tog_hit) stat_ne <= ~stat_ne;
        else              stat_ne <= ~fifo_empty;
    end

    assign occ = fifo_empty ? '0 : fifo_count - 1'b1;

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            unique case (ofs)
                OFS_GIE:  bus_rdata[31] = gie;
                OFS_STAT: bus_rdata[0]  = stat_ne;
                OFS_IEN:  bus_rdata[0]  = ien;
                OFS_CTRL: begin
                    bus_rdata[31]       = conv_en;
                    bus_rdata[SM_W-1:0] = settle_mult;
                end
                OFS_DATA: if (!fifo_empty) bus_rdata[SMP_W-1:0] = fifo_head;
                OFS_OCC:  bus_rdata[CNT_W-1:0] = occ;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign bus_ack  = ack;
    assign smp_full = fifo_full;
    assign irq      = gie && ien && stat_ne;

    // R8: status tracks the queue one cycle behind when not toggled
    assert_stat_follow_R8: assert property (@(posedge clk) disable iff (rst)
        !tog_hit |=> (stat_ne == $past(!fifo_empty)));
    // R9: a toggle write inverts the status bit
    assert_stat_toggle_R9: assert property (@(posedge clk) disable iff (rst)
        tog_hit |=> (stat_ne != $past(stat_ne)));
    // R1: no read data outside an acknowledged read
    assert_rdata_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !bus_ack |-> (bus_rdata == 32'd0));
endmodule

// File: tb/tb_sample_regbank.sv
module tb_sample_regbank;
    localparam int ADDR_W = 12;
    localparam int SMP_W  = 16;
    localparam int SM_W   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0, bus_rnw = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_ack;
    logic              smp_wr = 1'b0;
    logic [SMP_W-1:0]  smp_data = '0;
    logic              smp_full, conv_en, irq;
    logic [SM_W-1:0]   settle_mult;

    int checks = 0, errors = 0;
    logic ack_n0, ack_n1, ack_n2, irq_n2;

    sample_regbank #(.ADDR_W(ADDR_W), .DEPTH(16), .SMP_W(SMP_W), .SM_W(SM_W)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rnw(bus_rnw),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .smp_wr(smp_wr), .smp_data(smp_data),
        .smp_full(smp_full), .conv_en(conv_en), .settle_mult(settle_mult), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic rnw, input logic [11:0] a, input logic [31:0] wd,
                        output logic [31:0] rd);
        @(negedge clk);
        ack_n0 = bus_ack;
        bus_sel = 1'b1; bus_rnw = rnw; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        ack_n1 = bus_ack;
        rd = bus_rdata;
        bus_sel = 1'b0;
        @(negedge clk);
        ack_n2 = bus_ack;
        irq_n2 = irq;
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] wd);
        logic [31:0] d;
        xfer(1'b0, a, wd, d);
    endtask

    task automatic push(input logic [15:0] v);
        @(negedge clk);
        smp_wr = 1'b1; smp_data = v;
        @(negedge clk);
        smp_wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 ack", {31'd0, bus_ack}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 full", {31'd0, smp_full}, 32'd0);
        xfer(1'b1, 12'h100, 0, d); chk("R1 ctrl", d, 32'd0);
        xfer(1'b1, 12'h01C, 0, d); chk("R1 gie", d, 32'd0);
        xfer(1'b1, 12'h108, 0, d); chk("R1 occ", d, 32'd0);
        xfer(1'b1, 12'h020, 0, d); chk("R1 stat", d, 32'd0);
    endtask

    task automatic t_ack;
        logic [31:0] d;
        xfer(1'b1, 12'h100, 0, d);
        chk("R2 ack before", {31'd0, ack_n0}, 32'd0);
        chk("R2 ack after sel", {31'd0, ack_n1}, 32'd1);
        chk("R2 ack released", {31'd0, ack_n2}, 32'd0);
        // select held for several cycles: a single pop only
        push(16'h0AAA); push(16'h0BBB);
        @(negedge clk);
        bus_sel = 1'b1; bus_rnw = 1'b1; bus_addr = 12'h104;
        repeat (4) @(negedge clk);
        bus_sel = 1'b0;
        repeat (2) @(negedge clk);
        xfer(1'b1, 12'h108, 0, d); chk("R2 one access per select", d, 32'd0);
        xfer(1'b1, 12'h104, 0, d); chk("R2 remaining sample", d, 32'h0BBB);
    endtask

    task automatic t_control;
        logic [31:0] d;
        wr(12'h100, 32'hFFFF_FFFF);
        xfer(1'b1, 12'h100, 0, d); chk("R3 ctrl mask", d, 32'h8000_000F);
        chk("R3 conv_en", {31'd0, conv_en}, 32'd1);
        chk("R3 settle", {28'd0, settle_mult}, 32'hF);
        wr(12'h100, 32'h0000_0005);
        xfer(1'b1, 12'h100, 0, d); chk("R3 ctrl value", d, 32'h5);
        chk("R3 conv_en off", {31'd0, conv_en}, 32'd0);
    endtask

    task automatic t_order_and_empty;
        logic [31:0] d;
        push(16'h1111); push(16'h2222); push(16'hFEDC);
        xfer(1'b1, 12'h104, 0, d); chk("R4 first", d, 32'h1111);
        xfer(1'b1, 12'h104, 0, d); chk("R4 second", d, 32'h2222);
        xfer(1'b1, 12'h104, 0, d); chk("R4 third zero-padded", d, 32'h0000_FEDC);
        xfer(1'b1, 12'h104, 0, d); chk("R5 empty read", d, 32'd0);
        xfer(1'b1, 12'h108, 0, d); chk("R5 occ after empty read", d, 32'd0);
        push(16'h3333);
        xfer(1'b1, 12'h104, 0, d); chk("R5 queue intact", d, 32'h3333);
    endtask

    task automatic t_fill;
        logic [31:0] d;
        for (int i = 1; i <= 16; i++) begin
            push(16'(16'h0100 + i));
            if (i == 1) begin
                xfer(1'b1, 12'h108, 0, d); chk("R6 one entry", d, 32'd0);
            end
            if (i == 9) begin
                xfer(1'b1, 12'h108, 0, d); chk("R6 nine entries", d, 32'd8);
            end
            if (i == 15) chk("R7 not full at 15", {31'd0, smp_full}, 32'd0);
        end
        chk("R7 full at 16", {31'd0, smp_full}, 32'd1);
        xfer(1'b1, 12'h108, 0, d); chk("R6 sixteen entries", d, 32'd15);
        push(16'hDEAD);
        xfer(1'b1, 12'h108, 0, d); chk("R7 drop keeps count", d, 32'd15);
        for (int i = 1; i <= 16; i++) begin
            xfer(1'b1, 12'h104, 0, d);
            chk("R7 drained order", d, 32'(16'h0100 + i));
        end
        xfer(1'b1, 12'h104, 0, d); chk("R7 dropped sample absent", d, 32'd0);
    endtask

    task automatic t_status_irq;
        logic [31:0] d;
        xfer(1'b1, 12'h020, 0, d); chk("R8 stat empty", d, 32'd0);
        push(16'h0042);
        @(negedge clk);
        xfer(1'b1, 12'h020, 0, d); chk("R8 stat nonempty", d, 32'd1);
        chk("R10 irq masked", {31'd0, irq}, 32'd0);
        wr(12'h028, 32'd1);
        chk("R10 irq needs gie", {31'd0, irq}, 32'd0);
        wr(12'h01C, 32'h8000_0000);
        chk("R10 irq on", {31'd0, irq}, 32'd1);
        xfer(1'b1, 12'h01C, 0, d); chk("R10 gie readback", d, 32'h8000_0000);
        wr(12'h020, 32'd1);
        chk("R9 toggle clears", {31'd0, irq_n2}, 32'd0);
        chk("R8 restored after toggle", {31'd0, irq}, 32'd1);
        wr(12'h020, 32'd0);
        chk("R9 zero write no effect", {31'd0, irq_n2}, 32'd1);
        xfer(1'b1, 12'h104, 0, d); chk("R4 pop", d, 32'h42);
        chk("R8 irq drops when empty", {31'd0, irq}, 32'd0);
        wr(12'h020, 32'd1);
        chk("R9 toggle sets", {31'd0, irq_n2}, 32'd1);
        chk("R8 re-evaluated", {31'd0, irq}, 32'd0);
        wr(12'h028, 32'd0);
        wr(12'h020, 32'd1);
        chk("R10 ien gates", {31'd0, irq_n2}, 32'd0);
    endtask

    task automatic t_readonly;
        logic [31:0] d;
        push(16'h1234);
        wr(12'h104, 32'h0000_5555);
        wr(12'h108, 32'h0000_001F);
        xfer(1'b1, 12'h108, 0, d); chk("R11 occ unchanged", d, 32'd0);
        xfer(1'b1, 12'h104, 0, d); chk("R11 data unchanged", d, 32'h1234);
        xfer(1'b1, 12'h0F0, 0, d); chk("R11 unmapped", d, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_ack;
        t_control;
        t_order_and_empty;
        t_fill;
        t_status_irq;
        t_readonly;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule